// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors and a chooser. The local component keeps a short outcome history for each of several branch slots, picked by bits of the fetch address. That history indexes a table of two-bit saturating counters. The global component indexes its own counter table with the shift register of recent outcomes from all branches. A chooser table, indexed by the same global history, selects which of the two component predictions becomes the final answer.

Lookup is purely combinational. Given a fetch PC, the block returns in the same cycle the final prediction, both component predictions, the history slot selected and the two table indices. The pipeline carries these values with the branch. When the branch retires, it returns them with the real outcome on the update port. Both component counters at the supplied indices move toward the outcome. The selected local history and the global history each shift the outcome in. The chooser entry is trained only when the two components gave different predictions.

Top module: `tournament_bp`

## Requirements
- R1: After synchronous reset every history is all zeros, every component counter is 01 (weakly not-taken) and every chooser counter is 10, so a lookup returns local, global and final predictions of 0 with both indices 0.
- R2: The local history slot is chosen by PC bits [5:2] and reported on `lk_lhr_sel`; PC bits [1:0] and bits above 5 have no effect on it.
- R3: The local index equals the history of the selected slot; an update shifts the outcome into slot `up_lhr_sel` at bit 0, dropping the oldest bit.
- R4: The global index equals the global history; every update shifts the outcome into bit 0.
- R5: A component prediction is the MSB of its two-bit counter; an update moves the local counter at `up_local_idx` and the global counter at `up_global_idx` one step toward the outcome (up when taken).
- R6: The chooser entry at the global index selects the final prediction: MSB 1 gives the global prediction, MSB 0 the local one.
- R7: The chooser entry at `up_global_idx` changes only when `up_local_pred` differs from `up_global_pred`; it then steps up (toward global) if the global prediction matched the outcome, otherwise down.
- R8: Every counter increment stops at 3 and every decrement stops at 0.
- R9: With `up_valid` low no history or counter changes, whatever the other update inputs carry.
- R10: Lookup outputs follow `lk_pc` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Fetch PC to predict |
| lk_taken | output | 1 | Final prediction |
| lk_local_pred | output | 1 | Local component prediction |
| lk_global_pred | output | 1 | Global component prediction |
| lk_lhr_sel | output | 4 | Selected local history slot |
| lk_local_idx | output | 10 | Local counter index (selected history) |
| lk_global_idx | output | 12 | Global counter and chooser index |
| up_valid | input | 1 | Retirement update strobe |
| up_taken | input | 1 | Resolved outcome |
| up_local_pred | input | 1 | Local prediction made at lookup |
| up_global_pred | input | 1 | Global prediction made at lookup |
| up_lhr_sel | input | 4 | History slot used at lookup |
| up_local_idx | input | 10 | Local index used at lookup |
| up_global_idx | input | 12 | Global index used at lookup |

## Verification
The history assertions assume that retirement updates reach the block only through `up_valid`. They also assume that the fetch PC holds still across a cycle when the local shift is being compared. The bench changes `lk_pc` and every update input only on falling edges, and it pulses `up_valid` for one cycle per update. Between checks it brings the global history back to zero with not-taken updates aimed at indices it never observes. This lets a single counter or chooser entry be trained and then read back at index 0 without disturbing the entries under test.

// File: rtl/tourn_bp_pkg.sv
package tourn_bp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_NT     = 2'b01;
    localparam ctr2_t CTR_WEAK_GLOBAL = 2'b10;
    localparam ctr2_t CTR_MAX         = 2'b11;
    localparam ctr2_t CTR_MIN         = 2'b00;

    // Resolved branch flags carried back at retirement
    typedef struct packed {
        logic valid;
        logic taken;
        logic local_pred;
        logic global_pred;
    } retire_flags_t;

    // One saturating step of a two-bit counter
    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        if (up) return (c == CTR_MAX) ? CTR_MAX : ctr2_t'(c + 2'd1);
        else    return (c == CTR_MIN) ? CTR_MIN : ctr2_t'(c - 2'd1);
    endfunction

    // Counter MSB is the predicted direction
    function automatic logic ctr_dir(input ctr2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/sat_ctr_table.sv
module sat_ctr_table
    import tourn_bp_pkg::*;
#(
    parameter int    DEPTH     = 1024,
    parameter int    IDX_W     = $clog2(DEPTH),
    parameter ctr2_t RESET_VAL = CTR_WEAK_NT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    ctr2_t cells [DEPTH];

    assign rd_ctr = cells[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= RESET_VAL;
        end else if (wr_en) begin
            cells[wr_idx] <= ctr_step(cells[wr_idx], wr_up);
        end
    end

endmodule

// File: rtl/local_hist_file.sv
module local_hist_file #(
    parameter int NUM    = 16,
    parameter int HIST_W = 10,
    parameter int SEL_W  = $clog2(NUM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_bit
);

    logic [HIST_W-1:0] hist [NUM];

    assign rd_hist = hist[rd_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM; i++) hist[i] <= '0;
        end else if (wr_en) begin
            hist[wr_sel] <= {hist[wr_sel][HIST_W-2:0], wr_bit};
        end
    end

endmodule

// File: rtl/global_hist_reg.sv
module global_hist_reg #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);

    always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
    end

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
    import tourn_bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_LSB  = 2,
    parameter int LHR_NUM = 16,
    parameter int LHIST_W = 10,
    parameter int GHIST_W = 12,
    parameter int SEL_W   = $clog2(LHR_NUM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PC_W-1:0]    lk_pc,
    output logic               lk_taken,
    output logic               lk_local_pred,
    output logic               lk_global_pred,
    output logic [SEL_W-1:0]   lk_lhr_sel,
    output logic [LHIST_W-1:0] lk_local_idx,
    output logic [GHIST_W-1:0] lk_global_idx,
    input  logic               up_valid,
    input  logic               up_taken,
    input  logic               up_local_pred,
    input  logic               up_global_pred,
    input  logic [SEL_W-1:0]   up_lhr_sel,
    input  logic [LHIST_W-1:0] up_local_idx,
    input  logic [GHIST_W-1:0] up_global_idx
);

    localparam int LPHT_DEPTH = 1 << LHIST_W;
    localparam int GPHT_DEPTH = 1 << GHIST_W;
    localparam int SEL_HI     = PC_LSB + SEL_W;

    retire_flags_t rf;
    ctr2_t         local_ctr, global_ctr, choice_ctr;
    logic          choice_we, choice_up;
    logic          unused_pc_bits;

    assign rf = '{valid: up_valid, taken: up_taken,
                  local_pred: up_local_pred, global_pred: up_global_pred};

    // Slot select from PC, byte offset and high bits discarded
    assign lk_lhr_sel     = lk_pc[SEL_HI-1:PC_LSB];
    assign unused_pc_bits = ^{lk_pc[PC_W-1:SEL_HI], lk_pc[PC_LSB-1:0]};

    local_hist_file #(.NUM(LHR_NUM), .HIST_W(LHIST_W), .SEL_W(SEL_W)) u_lhist (
        .clk    (clk),
        .rst    (rst),
        .rd_sel (lk_lhr_sel),
        .rd_hist(lk_local_idx),
        .wr_en  (rf.valid),
        .wr_sel (up_lhr_sel),
        .wr_bit (rf.taken)
    );

    global_hist_reg #(.HIST_W(GHIST_W)) u_ghist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (rf.valid),
        .shift_bit(rf.taken),
        .hist     (lk_global_idx)
    );

    sat_ctr_table #(.DEPTH(LPHT_DEPTH), .IDX_W(LHIST_W), .RESET_VAL(CTR_WEAK_NT)) u_lpht (
        .clk   (clk),
        .rst   (rst),
        .rd_idx(lk_local_idx),
        .rd_ctr(local_ctr),
        .wr_en (rf.valid),
        .wr_idx(up_local_idx),
        .wr_up (rf.taken)
    );

    sat_ctr_table #(.DEPTH(GPHT_DEPTH), .IDX_W(GHIST_W), .RESET_VAL(CTR_WEAK_NT)) u_gpht (
        .clk   (clk),
        .rst   (rst),
        .rd_idx(lk_global_idx),
        .rd_ctr(global_ctr),
        .wr_en (rf.valid),
        .wr_idx(up_global_idx),
        .wr_up (rf.taken)
    );

    // Chooser trains only on disagreement, toward the component that was right
    assign choice_we = rf.valid && (rf.local_pred != rf.global_pred);
    assign choice_up = (rf.global_pred == rf.taken);

    sat_ctr_table #(.DEPTH(GPHT_DEPTH), .IDX_W(GHIST_W), .RESET_VAL(CTR_WEAK_GLOBAL)) u_choice (
        .clk   (clk),
        .rst   (rst),
        .rd_idx(lk_global_idx),
        .rd_ctr(choice_ctr),
        .wr_en (choice_we),
        .wr_idx(up_global_idx),
        .wr_up (choice_up)
    );

    assign lk_local_pred  = ctr_dir(local_ctr);
    assign lk_global_pred = ctr_dir(global_ctr);
    assign lk_taken       = ctr_dir(choice_ctr) ? lk_global_pred : lk_local_pred;

endmodule

// File: rtl/tourn_bp_checker.sv
module tourn_bp_checker #(
    parameter int PC_W    = 32,
    parameter int PC_LSB  = 2,
    parameter int LHIST_W = 10,
    parameter int GHIST_W = 12,
    parameter int SEL_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [PC_W-1:0]    lk_pc,
    input logic               lk_taken,
    input logic               lk_local_pred,
    input logic               lk_global_pred,
    input logic [LHIST_W-1:0] lk_local_idx,
    input logic [GHIST_W-1:0] lk_global_idx,
    input logic               up_valid,
    input logic               up_taken,
    input logic [SEL_W-1:0]   up_lhr_sel
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> lk_global_idx == '0); // R1

    AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> lk_global_idx == {$past(lk_global_idx[GHIST_W-2:0]), $past(up_taken)}); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> lk_global_idx == $past(lk_global_idx)); // R9

    AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (up_valid && lk_pc[PC_LSB +: SEL_W] == up_lhr_sel) |=>
        (lk_pc != $past(lk_pc)) ||
        (lk_local_idx == {$past(lk_local_idx[LHIST_W-2:0]), $past(up_taken)})); // R3

    AST_FINAL_FROM_COMPONENT: assert property (@(posedge clk) disable iff (rst)
        (lk_taken == lk_local_pred) || (lk_taken == lk_global_pred)); // R6

endmodule

bind tournament_bp tourn_bp_checker #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W), .SEL_W(SEL_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_pc         (lk_pc),
    .lk_taken      (lk_taken),
    .lk_local_pred (lk_local_pred),
    .lk_global_pred(lk_global_pred),
    .lk_local_idx  (lk_local_idx),
    .lk_global_idx (lk_global_idx),
    .up_valid      (up_valid),
    .up_taken      (up_taken),
    .up_lhr_sel    (up_lhr_sel)
);

// File: tb/tournament_bp_bench.sv
module tournament_bp_bench;

    localparam int HALF = 2;   // 4 ns period, 250 MHz

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_pc = '0;
    logic        lk_taken, lk_local_pred, lk_global_pred;
    logic [3:0]  lk_lhr_sel;
    logic [9:0]  lk_local_idx;
    logic [11:0] lk_global_idx;
    logic        up_valid = 1'b0, up_taken = 1'b0;
    logic        up_local_pred = 1'b0, up_global_pred = 1'b0;
    logic [3:0]  up_lhr_sel = '0;
    logic [9:0]  up_local_idx = '0;
    logic [11:0] up_global_idx = '0;

    int checks = 0;
    int errors = 0;

    always #HALF clk = ~clk;

    tournament_bp u_tournament_bp (
        .clk(clk), .rst(rst), .lk_pc(lk_pc),
        .lk_taken(lk_taken), .lk_local_pred(lk_local_pred), .lk_global_pred(lk_global_pred),
        .lk_lhr_sel(lk_lhr_sel), .lk_local_idx(lk_local_idx), .lk_global_idx(lk_global_idx),
        .up_valid(up_valid), .up_taken(up_taken),
        .up_local_pred(up_local_pred), .up_global_pred(up_global_pred),
        .up_lhr_sel(up_lhr_sel), .up_local_idx(up_local_idx), .up_global_idx(up_global_idx)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; up_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic upd(input int sel, input int lidx, input int gidx,
                       input bit t, input bit lp, input bit gp);
        @(negedge clk);
        up_valid = 1'b1; up_taken = t; up_local_pred = lp; up_global_pred = gp;
        up_lhr_sel = 4'(sel); up_local_idx = 10'(lidx); up_global_idx = 12'(gidx);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    // Not-taken updates to unobserved entries bring global history back to zero
    task automatic flush_ghist();
        for (int i = 0; i < 12; i++) upd(15, 1023, 4095, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic peek(input logic [31:0] pc);
        lk_pc = pc;
        #1;
    endtask

    task automatic t_reset_state();
        do_reset();
        peek(32'h0);
        check("R1 local_pred", lk_local_pred, 0);
        check("R1 global_pred", lk_global_pred, 0);
        check("R1 taken", lk_taken, 0);
        check("R1 local_idx", lk_local_idx, 0);
        check("R1 global_idx", lk_global_idx, 0);
    endtask

    task automatic t_pc_select();
        peek(32'h34);       check("R2 sel pc 0x34", lk_lhr_sel, 13);
        peek(32'h37);       check("R2 sel byte bits", lk_lhr_sel, 13);
        peek(32'hABC0_0F34); check("R10 R2 sel high bits", lk_lhr_sel, 13);
    endtask

    task automatic t_history();
        do_reset();
        upd(5, 1023, 4095, 1'b1, 1'b1, 1'b1);
        upd(5, 1023, 4095, 1'b0, 1'b1, 1'b1);
        upd(5, 1023, 4095, 1'b1, 1'b1, 1'b1);
        peek(32'h14);
        check("R3 local_idx slot5", lk_local_idx, 5);
        check("R4 global_idx", lk_global_idx, 5);
        peek(32'h18);
        check("R3 other slot untouched", lk_local_idx, 0);
        // Idle cycles with garbage on update inputs
        @(negedge clk);
        up_taken = 1'b1; up_lhr_sel = 4'd6; up_local_idx = 10'd0; up_global_idx = 12'd5;
        up_local_pred = 1'b0; up_global_pred = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check("R9 global_idx held", lk_global_idx, 5);
        check("R9 slot6 held", lk_local_idx, 0);
    endtask

    task automatic t_counters();
        do_reset();
        peek(32'h0);
        upd(1, 0, 4095, 1'b0, 1'b0, 1'b0);
        upd(1, 0, 4095, 1'b0, 1'b0, 1'b0);
        #1; check("R5 local ctr low", lk_local_pred, 0);
        upd(1, 0, 4095, 1'b1, 1'b1, 1'b1);
        upd(1, 0, 4095, 1'b1, 1'b1, 1'b1);
        #1; check("R8 floor at 0", lk_local_pred, 1);
        for (int i = 0; i < 3; i++) upd(1, 0, 4095, 1'b1, 1'b1, 1'b1);
        upd(1, 0, 4095, 1'b0, 1'b1, 1'b1);
        #1; check("R8 ceiling at 3", lk_local_pred, 1);
        upd(15, 1023, 0, 1'b1, 1'b1, 1'b1);
        upd(15, 1023, 0, 1'b1, 1'b1, 1'b1);
        flush_ghist();
        #1;
        check("R5 global ctr trained", lk_global_pred, 1);
        check("R4 global_idx flushed", lk_global_idx, 0);
    endtask

    task automatic t_chooser();
        do_reset();
        peek(32'h0);
        for (int i = 0; i < 3; i++) upd(15, 1023, 0, 1'b1, 1'b1, 1'b1);
        flush_ghist();
        #1;
        check("R6 local_pred", lk_local_pred, 0);
        check("R6 global_pred", lk_global_pred, 1);
        check("R6 chooser picks global", lk_taken, 1);
        upd(15, 1023, 0, 1'b0, 1'b0, 1'b1);
        #1;
        check("R7 global still 1", lk_global_pred, 1);
        check("R7 chooser toward local", lk_taken, 0);
        upd(15, 1023, 0, 1'b1, 1'b1, 1'b1);
        flush_ghist();
        #1; check("R7 agreement leaves chooser", lk_taken, 0);
        upd(15, 1023, 0, 1'b1, 1'b0, 1'b1);
        flush_ghist();
        #1; check("R7 chooser toward global", lk_taken, 1);
    endtask

    initial begin
        #(HALF * 2 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_pc_select();
        t_history();
        t_counters();
        t_chooser();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule